// File: doc/BRIEF.md
# Clock Ratio and Sync Monitor

The block runs on the converter's system clock and watches the word clock, which is sampled in the same clock domain. It counts the system-clock cycles between rising word-clock edges. It recognises a rate of 256, 384 or 512 cycles per sample and locks onto it. Once locked, it produces a clock enable that fires 256 times per sample period, whatever the ratio. The converter's processing logic uses that enable as its common internal rate.

In slave mode the block keeps a free-running phase counter that is aligned at lock. It compares every later word-clock edge against that counter. A small phase offset is tolerated without realignment. A larger one drops the lock, stops the enable and mutes the sample output, and the block then acquires the clock again. After each lock the output stays muted for a fixed number of sample periods. During that window a stricter offset limit applies, so the monitor has hysteresis. In master mode the word clock comes from the local clock tree, so the block never drops a lock it already holds.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: While reset is held and right after it, `ratio` is 0, `sync_ok` is 0, `mute` is 1 and `en256` is 0.
- R2: Lock needs two consecutive word-clock periods of exactly the same valid length. It is reported after the edge that closes the second period, so the third rising edge after reset. `ratio` reports 1 for 256, 2 for 384 and 3 for 512 cycles per sample. It stays constant while the lock holds.
- R3: A period length other than 256, 384 or 512 cycles never produces a lock.
- R4: While locked, `en256` is high on exactly 256 cycles out of any span of one nominal period. At ratio 512 it never stays high on two consecutive cycles. While unlocked it stays 0.
- R5: `mute` stays 1 from the lock edge through the next 31 word-clock edges. It falls in the cycle after the 32nd edge that follows the lock edge.
- R6: In slave mode after the mute window, an edge whose distance from the phase set at lock is at most 6 bit-clock periods keeps the lock, and the phase is not realigned. A larger distance drops the lock. One bit-clock period is the nominal period divided by 64, so 4, 6 or 8 cycles.
- R7: In slave mode during the mute window, an edge 5 or more bit-clock periods away from the locked phase drops the lock.
- R8: Losing lock sets `ratio` to 0, `sync_ok` to 0 and `mute` to 1. When lost on an edge, lock returns on the second following edge if the two periods match.
- R9: In master mode (`slave` = 0) a held lock is never dropped, whatever the edge phase or a missing word clock.
- R10: In slave mode with lock held, 2N-1 cycles without a word-clock edge (N the nominal period) drop the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk | input | 1 | Word clock, synchronous to clk |
| slave | input | 1 | 1 = word clock is external and is monitored; 0 = master mode |
| ratio | output | 2 | Detected ratio code: 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| en256 | output | 1 | Processing enable at 256 times the sample rate |
| sync_ok | output | 1 | Lock is held |
| mute | output | 1 | Force sample output to zero code |

## Verification
Each status output is a register updated at the clock edge that first sees the word clock high. So lock, loss and unmute are all visible one cycle after the rising word-clock edge that causes them. The bench drives each word period as a whole number of cycles starting at a falling clock edge, and samples the outputs at the end of the period. By then the edge that opened it has long been registered. The bench derives every offset as the sum of the period lengths modulo the nominal period and compares it with the thresholds. It counts enables at rising edges between two falling-edge snapshots, so a window of p periods spans exactly p cycles.

// File: rtl/crsm_pkg.sv
package crsm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } mon_state_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_X256 = 2'd1,
        RT_X384 = 2'd2,
        RT_X512 = 2'd3
    } ratio_e;

endpackage

// File: rtl/crsm_period_class.sv
module crsm_period_class
    import crsm_pkg::*;
#(
    parameter int BASE = 256,
    parameter int CW   = 10
) (
    input  logic [CW-1:0] cnt,
    output ratio_e        cls
);
    localparam logic [CW:0] P_LO  = (CW+1)'(BASE);
    localparam logic [CW:0] P_MID = (CW+1)'(BASE * 3 / 2);
    localparam logic [CW:0] P_HI  = (CW+1)'(BASE * 2);

    logic [CW:0] period;

    always_comb begin
        period = {1'b0, cnt} + (CW+1)'(1);
        if (period == P_LO)       cls = RT_X256;
        else if (period == P_MID) cls = RT_X384;
        else if (period == P_HI)  cls = RT_X512;
        else                      cls = RT_NONE;
    end
endmodule

// File: rtl/crsm_drift_eval.sv
module crsm_drift_eval
    import crsm_pkg::*;
#(
    parameter int BASE     = 256,
    parameter int PW       = 9,
    parameter int CW       = 10,
    parameter int LOSE_BCK = 6,
    parameter int HOLD_BCK = 5
) (
    input  ratio_e        ratio,
    input  logic [PW-1:0] ph,
    input  logic [CW-1:0] cnt,
    output logic [PW-1:0] nom_m1,
    output logic          run_bad,
    output logic          hold_bad,
    output logic          timeout
);
    int nom;
    int phi;
    int off;
    int bck;

    always_comb begin
        case (ratio)
            RT_X384: nom = BASE * 3 / 2;
            RT_X512: nom = BASE * 2;
            default: nom = BASE;
        endcase
        phi      = int'(ph);
        // distance to the nearest expected edge, early or late
        off      = (phi < nom / 2) ? phi : nom - phi;
        bck      = nom / 64;
        run_bad  = off > LOSE_BCK * bck;
        hold_bad = off >= HOLD_BCK * bck;
        timeout  = int'(cnt) >= 2 * nom - 1;
        nom_m1   = PW'(nom - 1);
    end
endmodule

// File: rtl/crsm_rate_div.sv
module crsm_rate_div
    import crsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active,
    input  logic   restart,
    input  ratio_e ratio,
    output logic   en
);
    logic [1:0] sub_d, sub_q;

    always_comb begin
        if (restart)
            sub_d = 2'd1;
        else if (ratio == RT_X384)
            sub_d = (sub_q == 2'd2) ? 2'd0 : sub_q + 2'd1;
        else
            sub_d = (sub_q == 2'd1) ? 2'd0 : sub_q + 2'd1;

        case (ratio)
            RT_X256: en = active;
            RT_X384: en = active && (sub_q != 2'd2);
            RT_X512: en = active && (sub_q == 2'd0);
            default: en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= 2'd0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
    import crsm_pkg::*;
#(
    parameter int BASE        = 256,
    parameter int MUTE_FRAMES = 32,
    parameter int LOSE_BCK    = 6,
    parameter int HOLD_BCK    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wclk,
    input  logic       slave,
    output logic [1:0] ratio,
    output logic       en256,
    output logic       sync_ok,
    output logic       mute
);
    localparam int CW = $clog2(4 * BASE);
    localparam int PW = $clog2(2 * BASE);
    localparam int FW = $clog2(MUTE_FRAMES + 1);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        mon_state_e    st;
        ratio_e        rt;
        ratio_e        prev;
        logic [CW-1:0] cnt;
        logic [PW-1:0] ph;
        logic [FW-1:0] frames;
        logic          wprev;
    } mon_t;

    mon_t r_q, r_d;

    ratio_e        cls;
    logic [PW-1:0] nom_m1;
    logic          run_bad, hold_bad, timeout;
    logic          edge_w, lose, restart;

    crsm_period_class #(.BASE(BASE), .CW(CW)) u_class (
        .cnt (r_q.cnt),
        .cls (cls)
    );

    crsm_drift_eval #(
        .BASE(BASE), .PW(PW), .CW(CW),
        .LOSE_BCK(LOSE_BCK), .HOLD_BCK(HOLD_BCK)
    ) u_drift (
        .ratio    (r_q.rt),
        .ph       (r_q.ph),
        .cnt      (r_q.cnt),
        .nom_m1   (nom_m1),
        .run_bad  (run_bad),
        .hold_bad (hold_bad),
        .timeout  (timeout)
    );

    always_comb begin
        r_d     = r_q;
        lose    = 1'b0;
        edge_w  = wclk & ~r_q.wprev;
        r_d.wprev = wclk;
        r_d.cnt = edge_w ? '0 : ((r_q.cnt == CMAX) ? r_q.cnt : r_q.cnt + 1'b1);
        r_d.ph  = (r_q.ph == nom_m1) ? '0 : r_q.ph + 1'b1;

        case (r_q.st)
            ST_HUNT: begin
                r_d.ph = '0;
                if (edge_w) begin
                    if (cls != RT_NONE && cls == r_q.prev) begin
                        r_d.st     = ST_HOLD;
                        r_d.rt     = cls;
                        r_d.ph     = PW'(1);
                        r_d.frames = '0;
                        r_d.prev   = RT_NONE;
                    end else begin
                        r_d.prev = cls;
                    end
                end
            end
            ST_HOLD: begin
                if (slave && timeout)
                    lose = 1'b1;
                else if (edge_w) begin
                    if (slave && hold_bad)
                        lose = 1'b1;
                    else if (r_q.frames == FW'(MUTE_FRAMES - 1))
                        r_d.st = ST_RUN;
                    else
                        r_d.frames = r_q.frames + 1'b1;
                end
            end
            ST_RUN: begin
                if (slave && (timeout || (edge_w && run_bad)))
                    lose = 1'b1;
            end
            default: lose = 1'b1;
        endcase

        if (lose) begin
            r_d.st     = ST_HUNT;
            r_d.rt     = RT_NONE;
            r_d.prev   = RT_NONE;
            r_d.ph     = '0;
            r_d.frames = '0;
        end

        restart = (r_q.st == ST_HUNT) && (r_d.st == ST_HOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_HUNT;
            r_q.rt     <= RT_NONE;
            r_q.prev   <= RT_NONE;
            r_q.cnt    <= CMAX;
            r_q.ph     <= '0;
            r_q.frames <= '0;
            r_q.wprev  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    crsm_rate_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (r_q.st != ST_HUNT),
        .restart (restart),
        .ratio   (r_q.rt),
        .en      (en256)
    );

    assign ratio   = r_q.rt;
    assign sync_ok = (r_q.st != ST_HUNT);
    assign mute    = (r_q.st != ST_RUN);
endmodule

// File: rtl/clk_ratio_sync_mon_chk.sv
module clk_ratio_sync_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wclk,
    input logic       slave,
    input logic [1:0] ratio,
    input logic       en256,
    input logic       sync_ok,
    input logic       mute
);
    a_r8_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |-> (mute && ratio == 2'd0 && !en256));

    a_r2_ratio_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && $past(sync_ok)) |-> $stable(ratio));

    a_r4_no_back_to_back_512: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == 2'd3 && en256) |=> !en256);

    a_r9_master_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave && sync_ok) |=> sync_ok);

    a_r5_unmute_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> ($past(wclk) && !$past(wclk, 2)));

    a_r2_lock_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> ($past(wclk) && !$past(wclk, 2) && ratio != 2'd0));
endmodule

bind clk_ratio_sync_mon clk_ratio_sync_mon_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wclk    (wclk),
    .slave   (slave),
    .ratio   (ratio),
    .en256   (en256),
    .sync_ok (sync_ok),
    .mute    (mute)
);

// File: tb/clk_ratio_sync_mon_bench.sv
module clk_ratio_sync_mon_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk = 1'b0;
    logic       slave = 1'b1;
    logic [1:0] ratio;
    logic       en256, sync_ok, mute;

    int checks = 0;
    int failures = 0;
    int en_acc = 0;

    always #4 clk = ~clk;

    clk_ratio_sync_mon u_clk_ratio_sync_mon (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .slave(slave),
        .ratio(ratio), .en256(en256), .sync_ok(sync_ok), .mute(mute)
    );

    always @(posedge clk) en_acc <= en_acc + int'(en256);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one word-clock period of p cycles, rising edge at its start
    task automatic wper(input int p);
        @(negedge clk) wclk = 1'b1;
        repeat (p / 2 - 1) @(negedge clk);
        wclk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic wrep(input int n, input int p);
        for (int i = 0; i < n; i++) wper(p);
    endtask

    task automatic en_window(input string tag, input int p, input int exp);
        int a;
        a = en_acc;
        wper(p);
        chk(tag, en_acc - a, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 ratio", int'(ratio), 0);
        chk("R1 sync", int'(sync_ok), 0);
        chk("R1 mute", int'(mute), 1);
        chk("R1 en", int'(en256), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mute after release", int'(mute), 1);

        // R2 lock at 256
        wrep(2, 256);
        chk("R2 no lock yet", int'(sync_ok), 0);
        wper(256);
        chk("R2 sync", int'(sync_ok), 1);
        chk("R2 ratio256", int'(ratio), 1);
        chk("R5 muted at lock", int'(mute), 1);
        wrep(31, 256);
        chk("R5 muted 31 edges", int'(mute), 1);
        wper(256);
        chk("R5 unmute 32nd", int'(mute), 0);
        en_window("R4 en count 256", 256, 256);

        // R6 cumulative drift, offsets 16, 24, 25
        wper(272);
        wper(264);
        chk("R6 off16 sync", int'(sync_ok), 1);
        chk("R6 off16 mute", int'(mute), 0);
        wper(257);
        chk("R6 off24 sync", int'(sync_ok), 1);
        wper(256);
        chk("R6 off25 lost", int'(sync_ok), 0);
        chk("R8 mute on loss", int'(mute), 1);
        chk("R8 ratio on loss", int'(ratio), 0);

        // R8 relock, R7 strict window
        wper(256);
        chk("R8 one period", int'(sync_ok), 0);
        wper(276);
        chk("R8 relock", int'(sync_ok), 1);
        wper(256);
        chk("R7 off20 in window lost", int'(sync_ok), 0);
        wper(256);
        wper(275);
        chk("R7 relock", int'(sync_ok), 1);
        wrep(31, 256);
        chk("R7 off19 kept", int'(sync_ok), 1);
        chk("R7 still muted", int'(mute), 1);
        wper(256);
        chk("R5 unmute after drifted window", int'(mute), 0);

        // R3 invalid period
        wrep(5, 300);
        chk("R3 no lock 300", int'(sync_ok), 0);
        chk("R3 ratio 300", int'(ratio), 0);
        en_window("R4 no en unlocked", 300, 0);

        // 384
        wrep(2, 384);
        chk("R2 384 not yet", int'(sync_ok), 0);
        wper(384);
        chk("R2 ratio384", int'(ratio), 2);
        wrep(32, 384);
        chk("R5 unmute 384", int'(mute), 0);
        en_window("R4 en count 384", 384, 256);

        // switch to 512
        wrep(2, 512);
        chk("R8 ratio change lost", int'(sync_ok), 0);
        wrep(2, 512);
        chk("R2 ratio512", int'(ratio), 3);
        wrep(32, 512);
        chk("R5 unmute 512", int'(mute), 0);
        en_window("R4 en count 512", 512, 256);

        // R9 master mode
        slave = 1'b0;
        wper(612);
        wper(512);
        chk("R9 master big offset", int'(sync_ok), 1);
        chk("R9 master unmuted", int'(mute), 0);
        repeat (3000) @(negedge clk);
        chk("R9 master no wclk", int'(sync_ok), 1);

        // R10 timeout in slave mode
        slave = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 timeout lost", int'(sync_ok), 0);
        chk("R10 mute", int'(mute), 1);
        chk("R10 ratio", int'(ratio), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule